// File: doc/BRIEF.md
# Bit-granular anticollision response shifter

This block answers the anticollision and select frames that a card sends back to a reader. The reader's frame may stop at any bit, not only after a whole byte. The block receives the decoded data bits of the frame (parity already removed) together with an end-of-frame strobe. It reads the valid-bit descriptor that the frame carries, compares every identifier bit the reader sent against the stored identifier, and then sends only the rest of the prepared response. The prepared response is the identifier followed by its check byte. Transmission starts at exactly the bit where the reader stopped.

The response is never re-encoded. A bit pointer starts at the received offset and walks the prepared sequence, inserting an odd parity bit after every byte that is sent whole. When the reader has already sent all forty bits, the frame is a select. The block then raises a one-cycle acknowledge flag and does not transmit.

Top module: `ac_resp_shifter`

## Requirements
- R1: After reset, tx_valid, tx_bit, done and sel_ack are all 0.
- R2: Frame bits arrive LSB first. A bit is taken on a cycle where rx_valid is 1 and rx_end is 0. Bits 0..7 are the command byte, whose value is not checked. Bits 8..15 are the descriptor byte. Its bits [7:4] give the byte count including the two command bytes, and its bits [3:0] give the extra bit count. The number of identifier bits k = (bits[7:4] − 2)·8 + bits[3:0].
- R3: After a valid frame with k < 40, tx_valid rises in the cycle after the rx_end cycle. tx_bit then carries stream bits k, k+1, … up to bit 39, one bit per cycle with no gaps. Stream bit i is bit (i mod 8) of response byte i/8.
- R4: Bytes 0..3 of the response are uid[7:0], uid[15:8], uid[23:16] and uid[31:24]. Byte 4 is the XOR of those four bytes.
- R5: An odd parity bit is sent directly after the eighth bit of every response byte that was sent whole. The parity bit makes the number of ones across the byte and the parity bit odd.
- R6: When k is not a multiple of 8, the partial byte at offset k gets no parity bit, and parity resumes from the next byte.
- R7: If any received identifier bit differs from stream bit i of the response, no output is produced for that frame.
- R8: No output is produced for the frame in any of these cases: the frame is shorter than 16 bits, bits[7:4] < 2, bits[3:0] > 7, k > 40, or the number of received identifier bits is not k.
- R9: A valid frame with k = 40 makes sel_ack 1 for exactly the one cycle after the rx_end cycle. tx_valid stays 0.
- R10: done is 1 for one cycle, in the cycle directly after the last transmitted bit. tx_valid is 0 in that cycle.
- R11: While tx_valid is 1, rx_valid and rx_end have no effect on the response being sent or on the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received data bit strobe |
| rx_bit | input | 1 | Received data bit |
| rx_end | input | 1 | End-of-frame strobe |
| uid | input | 32 | Stored identifier, byte 0 in bits [7:0] |
| tx_valid | output | 1 | Transmit bit valid |
| tx_bit | output | 1 | Transmit data or parity bit |
| done | output | 1 | One-cycle pulse after the last transmitted bit |
| sel_ack | output | 1 | One-cycle select acknowledge |

## Verification
Several internal faults show up at the ports. A wrong start offset or a bad pointer step shifts every bit that follows, so the fault appears in the first transmitted cycle after rx_end. A parity-suppression flag that is stuck or cleared at the wrong time either adds or drops a bit at the first byte boundary, and the whole rest of the stream then slips by one cycle. A receive counter or mismatch flag that is corrupted changes the decision taken at rx_end, so a response appears where there should be silence, or the reverse, in the very next cycle. The bench compares all four outputs against a behavioural model on every cycle. It covers offsets on and off byte boundaries, including a split that falls inside the check byte.

// File: rtl/ac_pkg.sv
package ac_pkg;
    localparam int HDR_BITS = 16;

    function automatic logic odd_par(input logic [7:0] b);
        return ~^b;
    endfunction
endpackage

// File: rtl/ac_rx_track.sv
module ac_rx_track #(
    parameter int EXT_BITS = 40,
    parameter int CNT_W    = 7,
    parameter int POS_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                take,
    input  logic                bit_in,
    input  logic [EXT_BITS-1:0] ext,
    output logic [CNT_W-1:0]    cnt,
    output logic [7:0]          nvb,
    output logic                bad
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [7:0]       nvb;
        logic             bad;
    } rx_st_t;

    rx_st_t q, d;
    logic [POS_W-1:0] idx;

    always_comb begin
        d   = q;
        idx = POS_W'(q.cnt - CNT_W'(ac_pkg::HDR_BITS));
        if (clr) begin
            d = '0;
        end else if (take) begin
            if (q.cnt >= CNT_W'(8) && q.cnt < CNT_W'(ac_pkg::HDR_BITS)) begin
                d.nvb[q.cnt[2:0]] = bit_in;
            end else if (q.cnt >= CNT_W'(ac_pkg::HDR_BITS)) begin
                if (int'(q.cnt) - ac_pkg::HDR_BITS >= EXT_BITS)
                    d.bad = 1'b1;
                else if (bit_in != ext[idx])
                    d.bad = 1'b1;
            end
            if (q.cnt != '1)
                d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt = q.cnt;
    assign nvb = q.nvb;
    assign bad = q.bad;

    // R2: the bit count only grows within a frame
    p_cnt_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> cnt >= $past(cnt));
endmodule

// File: rtl/ac_tx_shift.sv
module ac_tx_shift #(
    parameter int EXT_BITS = 40,
    parameter int POS_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [POS_W-1:0]    start_pos,
    input  logic [EXT_BITS-1:0] ext,
    output logic                tx_valid,
    output logic                tx_bit,
    output logic                done
);
    localparam logic [POS_W-1:0] LAST = POS_W'(EXT_BITS - 1);

    typedef struct packed {
        logic             active;
        logic             par;
        logic             nopar;
        logic [POS_W-1:0] pos;
        logic             done;
    } tx_st_t;

    tx_st_t q, d;
    logic [7:0] cur_byte;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.active) begin
            if (start) begin
                d.active = 1'b1;
                d.pos    = start_pos;
                d.par    = 1'b0;
                d.nopar  = (start_pos[2:0] != 3'd0);
            end
        end else if (q.par) begin
            d.par = 1'b0;
            if (q.pos == LAST) begin
                d.active = 1'b0;
                d.done   = 1'b1;
            end else begin
                d.pos = q.pos + 1'b1;
            end
        end else if (q.pos[2:0] == 3'd7) begin
            if (q.nopar) begin
                d.nopar = 1'b0;
                if (q.pos == LAST) begin
                    d.active = 1'b0;
                    d.done   = 1'b1;
                end else begin
                    d.pos = q.pos + 1'b1;
                end
            end else begin
                d.par = 1'b1;
            end
        end else begin
            d.pos = q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cur_byte = ext[{q.pos[POS_W-1:3], 3'b000} +: 8];
    assign tx_valid = q.active;
    assign tx_bit   = q.active & (q.par ? ac_pkg::odd_par(cur_byte) : ext[q.pos]);
    assign done     = q.done;

    // R3: inside a byte the pointer advances one bit per cycle without gaps
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !q.par && q.pos[2:0] != 3'd7) |=> (tx_valid && !q.par && q.pos == $past(q.pos) + 1'b1));
    // R10: done follows the last transmitted bit with the line idle
    p_done_after_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(tx_valid) && !tx_valid));
endmodule

// File: rtl/ac_resp_shifter.sv
module ac_resp_shifter #(
    parameter int UID_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_valid,
    input  logic                   rx_bit,
    input  logic                   rx_end,
    input  logic [8*UID_BYTES-1:0] uid,
    output logic                   tx_valid,
    output logic                   tx_bit,
    output logic                   done,
    output logic                   sel_ack
);
    localparam int EXT_BITS = 8 * (UID_BYTES + 1);
    localparam int POS_W    = $clog2(EXT_BITS);
    localparam int CNT_W    = $clog2(ac_pkg::HDR_BITS + EXT_BITS + 1) + 1;

    typedef struct packed {
        logic sel_ack;
    } top_st_t;

    top_st_t q, d;

    logic [EXT_BITS-1:0] ext;
    logic [7:0]          bcc;
    logic [CNT_W-1:0]    cnt;
    logic [7:0]          nvb;
    logic                bad;
    logic                take, clr, frame_ok, start;
    int                  k_i;

    always_comb begin
        bcc = '0;
        for (int j = 0; j < UID_BYTES; j++)
            bcc = bcc ^ uid[8*j +: 8];
    end

    for (genvar j = 0; j < UID_BYTES; j++) begin : g_ext
        assign ext[8*j +: 8] = uid[8*j +: 8];
    end
    assign ext[EXT_BITS-1 -: 8] = bcc;

    assign take = rx_valid & ~rx_end & ~tx_valid;
    assign clr  = rx_end & ~tx_valid;

    ac_rx_track #(.EXT_BITS(EXT_BITS), .CNT_W(CNT_W), .POS_W(POS_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .clr(clr), .take(take), .bit_in(rx_bit),
        .ext(ext), .cnt(cnt), .nvb(nvb), .bad(bad)
    );

    always_comb begin
        k_i      = (int'(nvb[7:4]) - 2) * 8 + int'(nvb[3:0]);
        frame_ok = (int'(cnt) >= ac_pkg::HDR_BITS) && (nvb[7:4] >= 4'd2) &&
                   (nvb[3:0] <= 4'd7) && (k_i <= EXT_BITS) &&
                   (int'(cnt) == ac_pkg::HDR_BITS + k_i) && !bad;
        start    = clr && frame_ok && (k_i < EXT_BITS);
        d        = q;
        d.sel_ack = clr && frame_ok && (k_i == EXT_BITS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    ac_tx_shift #(.EXT_BITS(EXT_BITS), .POS_W(POS_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(start), .start_pos(POS_W'(k_i)),
        .ext(ext), .tx_valid(tx_valid), .tx_bit(tx_bit), .done(done)
    );

    assign sel_ack = q.sel_ack;

    // R9: acknowledge only right after an end-of-frame strobe
    p_sel_after_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ack |-> $past(rx_end));
    // R9: no transmission together with the acknowledge
    p_sel_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ack |-> !tx_valid);
    // R11: an end strobe while sending cannot raise an acknowledge
    p_busy_ignores_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && rx_end) |=> !sel_ack);
endmodule

// File: tb/sim_ac_resp_shifter.sv
`timescale 1ns/1ps
module sim_ac_resp_shifter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0, rx_bit = 1'b0, rx_end = 1'b0;
    logic [31:0] uid = '0;
    logic tx_valid, tx_bit, done, sel_ack;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    typedef struct { bit v; bit b; bit d; bit s; } exp_t;

    always #2 clk = ~clk;

    ac_resp_shifter u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_bit(rx_bit),
        .rx_end(rx_end), .uid(uid), .tx_valid(tx_valid), .tx_bit(tx_bit),
        .done(done), .sel_ack(sel_ack)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic cmp(input exp_t e, input string tag);
        checks++;
        if (tx_valid !== e.v || (e.v && tx_bit !== e.b) || done !== e.d || sel_ack !== e.s) begin
            errors++;
            $display("FAIL %s: actual v%b b%b d%b s%b expected v%b b%b d%b s%b",
                     tag, tx_valid, tx_bit, done, sel_ack, e.v, e.b, e.d, e.s);
        end
    endtask

    // model: prepared response bits, stream order LSB first per byte (R4)
    function automatic bit resp_bit(input logic [31:0] u, input int i);
        logic [7:0] c;
        c = u[7:0] ^ u[15:8] ^ u[23:16] ^ u[31:24];
        if (i < 32) return u[i];
        return c[i-32];
    endfunction

    function automatic bit par_of(input logic [31:0] u, input int byte_i);
        int ones = 0;
        for (int j = 0; j < 8; j++) ones += resp_bit(u, byte_i*8 + j);
        return (ones % 2) == 0;
    endfunction

    task automatic run_frame(input logic [31:0] u, input logic [7:0] nvb, input int ndata,
                             input int flip, input bit noise, input string tag);
        bit   bits[$];
        exp_t ex[$];
        exp_t idle;
        int hi, lo, k;
        bit ok;
        idle = '{0, 0, 0, 0};
        @(negedge clk);
        uid = u;
        for (int j = 0; j < 8; j++) bits.push_back(8'h93 >> j);
        for (int j = 0; j < 8; j++) bits.push_back(nvb[j]);
        for (int i = 0; i < ndata; i++)
            bits.push_back((i < 40 ? resp_bit(u, i) : 1'b0) ^ (i == flip));
        foreach (bits[i]) begin
            rx_valid = 1'b1; rx_bit = bits[i];
            @(negedge clk);
            cmp(idle, tag);
        end
        rx_valid = 1'b0; rx_end = 1'b1;
        @(negedge clk);
        rx_end = 1'b0;
        // expected response (R2, R3, R5, R6, R7, R8, R9, R10)
        hi = int'(nvb[7:4]); lo = int'(nvb[3:0]);
        k  = (hi - 2) * 8 + lo;
        ok = (hi >= 2) && (lo <= 7) && (k <= 40) && (ndata == k) && !(flip >= 0 && flip < ndata);
        if (ok && k == 40) begin
            ex.push_back('{0, 0, 0, 1});
        end else if (ok) begin
            for (int i = k; i < 40; i++) begin
                ex.push_back('{1, resp_bit(u, i), 0, 0});
                if (i % 8 == 7 && (k % 8 == 0 || i / 8 != k / 8))
                    ex.push_back('{1, par_of(u, i / 8), 0, 0});
            end
            ex.push_back('{0, 0, 1, 0});
        end
        for (int i = 0; i < 4; i++) ex.push_back(idle);
        foreach (ex[c]) begin
            cmp(ex[c], tag);
            if (noise && ex[c].v) begin
                rx_valid = 1'($urandom);
                rx_bit   = 1'($urandom);
                rx_end   = (c % 5 == 2);
            end else begin
                rx_valid = 1'b0; rx_end = 1'b0;
            end
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_end = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        cmp('{0, 0, 0, 0}, "R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        cmp('{0, 0, 0, 0}, "R1 after release");

        run_frame(32'hA53C91E7, 8'h20, 0,  -1, 0, "R3/R4/R5 k0");
        run_frame(32'hA53C91E7, 8'h40, 16, -1, 0, "R2/R3 k16");
        run_frame(32'hA53C91E7, 8'h35, 13, -1, 0, "R6 k13");
        run_frame(32'hA53C91E7, 8'h65, 37, -1, 0, "R6 k37 split check byte");
        run_frame(32'hA53C91E7, 8'h70, 40, -1, 0, "R9 select");
        run_frame(32'hA53C91E7, 8'h35, 13, 9,  0, "R7 mismatch");
        run_frame(32'hA53C91E7, 8'h70, 40, 35, 0, "R7 select mismatch");
        run_frame(32'hA53C91E7, 8'h35, 12, -1, 0, "R8 short count");
        run_frame(32'hA53C91E7, 8'h29, 9,  -1, 0, "R8 bad bit nibble");
        run_frame(32'hA53C91E7, 8'h10, 0,  -1, 0, "R8 low byte count");
        run_frame(32'h0F1E2D3C, 8'h30, 8,  -1, 1, "R11 noise while sending");
        run_frame(32'h0F1E2D3C, 8'h21, 1,  -1, 0, "R11 next frame clean R10");
        run_frame(32'hFFFFFFFF, 8'h57, 31, -1, 0, "R5/R6 k31");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule